// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit sits between a byte-wide SPI shift engine and a register bus. It holds two small byte queues: one collects bytes delivered by the shifter for software to read, and the other holds bytes written by software until the shifter asks for them. It assembles a 16-bit status word from the two occupancy counts, a level flag for receive backlog, four sticky event flags and a summary interrupt bit. It drives one interrupt line.

Software sets a direction bit and a 3-bit threshold. With the direction bit low, an interrupt is raised when arriving bytes bring the receive queue up to the threshold. With it high, the interrupt is raised when shifter requests drain the transmit queue down to the threshold. Overflow and underflow raise error interrupts. Those can be masked by holding the matching flush input, and a held flush also empties its queue. Each sticky flag clears on a status read, unless a new event arrives in the same cycle.

Top module: `spi_fifo_stat`

## Requirements
- R1: After synchronous reset the status word is 0x0000, the receive data output and the shifter byte output are 0x00, and irq is low.
- R2: Each queue holds 4 bytes and returns them in arrival order. The receive count sits in status bits 10:8 and the transmit count in bits 3:1, each as binary 0 to 4. Bits 15:12 read as zero.
- R3: A transmit data write while the transmit queue holds 4 bytes is dropped and leaves the queue unchanged.
- R4: A shifter byte that arrives while the receive queue holds 4 bytes is discarded, and the queue contents stay as they were. Status bit 7 (receive overflow) is set.
- R5: A shifter transmit request while the transmit queue is empty gives the shifter 0x00, sets status bit 4 (transmit underflow) and leaves the count at 0.
- R6: Status bit 11 is high exactly while the receive count is greater than the threshold input. It is not sticky.
- R7: With the direction bit at 0, a received byte that makes the receive count equal to the threshold sets status bit 6.
- R8: With the direction bit at 1, a shifter request that pops a byte and leaves the transmit count equal to the threshold sets status bit 5.
- R9: A status read clears bits 7, 6, 5, 4 and 0 at the end of the cycle, and the word seen during the read is the old value. A flag whose event occurs in the same cycle as the read stays set.
- R10: While a flush input is high, its queue reads as empty and its count is zero. Pushes into that queue are ignored, and the queue is still empty once the flush is released.
- R11: irq is the OR of bits 6 and 5, bit 7 unless the receive flush is high, and bit 4 unless the transmit flush is high. Status bit 0 is set by any flag event, so irq high implies bit 0 high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wr | input | 1 | Bus write strobe for the transmit data register |
| tx_wdata | input | 8 | Byte written to the transmit queue |
| rx_rd | input | 1 | Bus read strobe for the receive data register (pops one byte) |
| rx_rdata | output | 8 | Oldest receive byte, 0x00 when empty |
| stat_rd | input | 1 | Bus read strobe for the status register |
| stat_word | output | 16 | Status word |
| mode_tx | input | 1 | Threshold direction: 0 counts received bytes, 1 counts transmitted bytes |
| thresh | input | 3 | Byte-count threshold |
| rx_flush | input | 1 | Receive flush and overflow interrupt mask |
| tx_flush | input | 1 | Transmit flush and underflow interrupt mask |
| sh_rx_vld | input | 1 | Shifter received-byte strobe |
| sh_rx_byte | input | 8 | Byte from the shifter |
| sh_tx_req | input | 1 | Shifter transmit-start strobe, requests one byte |
| sh_tx_byte | output | 8 | Byte offered to the shifter, 0x00 when empty |
| irq | output | 1 | Interrupt line |

## Verification
The receive path is filled one byte at a time under a threshold of 2. This separates the count reaching the threshold, which sets the event flag, from the count passing it, which raises only the backlog level. The transmit path is drained with the direction bit high, so the flag must appear at the single pop that lands on the threshold and at no other pop. Overflow and underflow are provoked with the queues full and empty, alone and in the same cycle as a status read, to tell "read clears" apart from "event wins". Holding the flush inputs over an active error flag shows that the flush masks the line without clearing the flag.

// File: rtl/spi_fifo_stat_pkg.sv
package spi_fifo_stat_pkg;

    localparam int STAT_W  = 16;
    localparam int FCNT_W  = 3;

    typedef struct packed {
        logic ovf;
        logic rxi;
        logic txi;
        logic udf;
    } sfs_evt_t;

    typedef struct packed {
        logic ovf;
        logic rxi;
        logic txi;
        logic udf;
        logic gis;
    } sfs_flags_t;

    function automatic logic [STAT_W-1:0] build_status(
        input sfs_flags_t        f,
        input logic              excess,
        input logic [FCNT_W-1:0] rxc,
        input logic [FCNT_W-1:0] txc
    );
        logic [STAT_W-1:0] w;
        w        = '0;
        w[11]    = excess;
        w[10:8]  = rxc;
        w[7]     = f.ovf;
        w[6]     = f.rxi;
        w[5]     = f.txi;
        w[4]     = f.udf;
        w[3:1]   = txc;
        w[0]     = f.gis;
        return w;
    endfunction

    function automatic logic any_event(input sfs_evt_t e);
        return e.ovf | e.rxi | e.txi | e.udf;
    endfunction

endpackage

// File: rtl/sfs_fifo.sv
module sfs_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nxt,
    output logic          full,
    output logic          empty,
    output logic          push_ok,
    output logic          pop_ok
);

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DW-1:0] slot [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] cnt_q;

    assign cnt     = flush ? '0 : cnt_q;
    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push & ~full & ~flush;
    assign pop_ok  = pop & ~empty;
    assign cnt_nxt = flush ? '0 : (cnt_q + CW'(push_ok) - CW'(pop_ok));
    assign dout    = empty ? '0 : slot[rd_ptr];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[i] <= '0;
            end else if (push_ok && wr_ptr == PW'(i)) begin
                slot[i] <= din;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sfs_flags.sv
module sfs_flags
    import spi_fifo_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stat_rd,
    input  sfs_evt_t   evt,
    input  logic       rx_mask,
    input  logic       tx_mask,
    output sfs_flags_t flags,
    output logic       irq
);

    sfs_flags_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.ovf <= evt.ovf | (q.ovf & ~stat_rd);
            q.rxi <= evt.rxi | (q.rxi & ~stat_rd);
            q.txi <= evt.txi | (q.txi & ~stat_rd);
            q.udf <= evt.udf | (q.udf & ~stat_rd);
            q.gis <= any_event(evt) | (q.gis & ~stat_rd);
        end
    end

    assign flags = q;
    assign irq   = (q.ovf & ~rx_mask) | q.rxi | q.txi | (q.udf & ~tx_mask);

endmodule

// File: rtl/spi_fifo_stat.sv
module spi_fifo_stat
    import spi_fifo_stat_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_wdata,
    input  logic          rx_rd,
    output logic [DW-1:0] rx_rdata,
    input  logic          stat_rd,
    output logic [15:0]   stat_word,
    input  logic          mode_tx,
    input  logic [CW-1:0] thresh,
    input  logic          rx_flush,
    input  logic          tx_flush,
    input  logic          sh_rx_vld,
    input  logic [DW-1:0] sh_rx_byte,
    input  logic          sh_tx_req,
    output logic [DW-1:0] sh_tx_byte,
    output logic          irq
);

    logic [CW-1:0] rx_cnt, rx_cnt_nxt, tx_cnt, tx_cnt_nxt;
    logic          rx_full, rx_empty, rx_push_ok, rx_pop_ok;
    logic          tx_full, tx_empty, tx_push_ok, tx_pop_ok;
    sfs_evt_t      evt;
    sfs_flags_t    flags;
    logic          excess;

    sfs_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(sh_rx_vld), .din(sh_rx_byte), .pop(rx_rd), .dout(rx_rdata),
        .cnt(rx_cnt), .cnt_nxt(rx_cnt_nxt), .full(rx_full), .empty(rx_empty),
        .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
    );

    sfs_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk(clk), .rst(rst), .flush(tx_flush),
        .push(tx_wr), .din(tx_wdata), .pop(sh_tx_req), .dout(sh_tx_byte),
        .cnt(tx_cnt), .cnt_nxt(tx_cnt_nxt), .full(tx_full), .empty(tx_empty),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
    );

    always_comb begin
        evt.ovf = sh_rx_vld & rx_full;
        evt.rxi = ~mode_tx & rx_push_ok & (rx_cnt_nxt == thresh);
        evt.txi = mode_tx & tx_pop_ok & (tx_cnt_nxt == thresh);
        evt.udf = sh_tx_req & tx_empty;
    end

    sfs_flags u_flags (
        .clk(clk), .rst(rst), .stat_rd(stat_rd), .evt(evt),
        .rx_mask(rx_flush), .tx_mask(tx_flush), .flags(flags), .irq(irq)
    );

    assign excess    = (rx_cnt > thresh);
    assign stat_word = build_status(flags, excess, rx_cnt, tx_cnt);

endmodule

// File: rtl/spi_fifo_stat_chk.sv
module spi_fifo_stat_chk (
    input logic        clk,
    input logic        rst,
    input logic        tx_wr,
    input logic        rx_rd,
    input logic        stat_rd,
    input logic        rx_flush,
    input logic        tx_flush,
    input logic        sh_rx_vld,
    input logic        sh_tx_req,
    input logic [15:0] stat_word,
    input logic        irq
);

    p_count_range_r2: assert property (@(posedge clk) disable iff (rst)
        stat_word[10:8] <= 3'd4 && stat_word[3:1] <= 3'd4 && stat_word[15:12] == 4'd0);

    p_tx_full_hold_r3: assert property (@(posedge clk) disable iff (rst)
        tx_wr && stat_word[3:1] == 3'd4 && !sh_tx_req |=> (tx_flush || stat_word[3:1] == 3'd4));

    p_ovf_set_r4: assert property (@(posedge clk) disable iff (rst)
        sh_rx_vld && stat_word[10:8] == 3'd4 |=> stat_word[7]);

    p_rx_full_hold_r4: assert property (@(posedge clk) disable iff (rst)
        sh_rx_vld && stat_word[10:8] == 3'd4 && !rx_rd |=> (rx_flush || stat_word[10:8] == 3'd4));

    p_udf_set_r5: assert property (@(posedge clk) disable iff (rst)
        sh_tx_req && stat_word[3:1] == 3'd0 |=> stat_word[4]);

    p_read_clear_r9: assert property (@(posedge clk) disable iff (rst)
        stat_rd && !sh_rx_vld && !sh_tx_req |=> (stat_word[7:4] == 4'd0 && !stat_word[0]));

    p_flush_empty_r10: assert property (@(posedge clk) disable iff (rst)
        rx_flush && !sh_rx_vld |=> stat_word[10:8] == 3'd0);

    p_irq_summary_r11: assert property (@(posedge clk) disable iff (rst)
        irq |-> stat_word[0]);

endmodule

bind spi_fifo_stat spi_fifo_stat_chk u_chk (
    .clk(clk), .rst(rst), .tx_wr(tx_wr), .rx_rd(rx_rd), .stat_rd(stat_rd),
    .rx_flush(rx_flush), .tx_flush(tx_flush), .sh_rx_vld(sh_rx_vld),
    .sh_tx_req(sh_tx_req), .stat_word(stat_word), .irq(irq)
);

// File: tb/spi_fifo_stat_test.sv
module spi_fifo_stat_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        tx_wr, rx_rd, stat_rd, mode_tx, rx_flush, tx_flush;
    logic        sh_rx_vld, sh_tx_req;
    logic [7:0]  tx_wdata, sh_rx_byte, rx_rdata, sh_tx_byte;
    logic [2:0]  thresh;
    logic [15:0] stat_word;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    spi_fifo_stat uut (
        .clk(clk), .rst(rst), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .stat_rd(stat_rd),
        .stat_word(stat_word), .mode_tx(mode_tx), .thresh(thresh),
        .rx_flush(rx_flush), .tx_flush(tx_flush), .sh_rx_vld(sh_rx_vld),
        .sh_rx_byte(sh_rx_byte), .sh_tx_req(sh_tx_req),
        .sh_tx_byte(sh_tx_byte), .irq(irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rx_in(input logic [7:0] b);
        sh_rx_vld = 1'b1; sh_rx_byte = b;
        tick();
        sh_rx_vld = 1'b0;
    endtask

    task automatic tx_in(input logic [7:0] b);
        tx_wr = 1'b1; tx_wdata = b;
        tick();
        tx_wr = 1'b0;
    endtask

    task automatic stat_read();
        stat_rd = 1'b1;
        tick();
        stat_rd = 1'b0;
    endtask

    task automatic rx_pop_chk(input string req, input logic [7:0] exp);
        chk(req, "rx byte", rx_rdata, exp);
        rx_rd = 1'b1;
        tick();
        rx_rd = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        tick();
        chk("R1", "status", stat_word, 16'h0000);
        chk("R1", "rx data", rx_rdata, 8'h00);
        chk("R1", "tx byte", sh_tx_byte, 8'h00);
        chk("R1", "irq", irq, 1'b0);
    endtask

    task automatic t_rx_threshold();
        mode_tx = 1'b0; thresh = 3'd2;
        rx_in(8'hA1);
        chk("R7", "status after 1 byte", stat_word, 16'h0100);
        rx_in(8'hB2);
        chk("R7", "status at threshold", stat_word, 16'h0241);
        chk("R11", "irq on rx event", irq, 1'b1);
        rx_in(8'hC3);
        chk("R6", "excess above threshold", stat_word, 16'h0B41);
        stat_read();
        chk("R9", "status after read", stat_word, 16'h0B00);
        chk("R9", "irq after read", irq, 1'b0);
        rx_pop_chk("R2", 8'hA1);
        chk("R6", "excess gone at threshold", stat_word, 16'h0200);
        rx_pop_chk("R2", 8'hB2);
        rx_pop_chk("R2", 8'hC3);
        chk("R2", "rx empty", stat_word, 16'h0000);
        chk("R2", "rx data empty", rx_rdata, 8'h00);
    endtask

    task automatic t_rx_overflow();
        mode_tx = 1'b0; thresh = 3'd4;
        for (int i = 0; i < 4; i++) rx_in(8'h10 + 8'(i));
        stat_read();
        chk("R2", "rx full count", stat_word, 16'h0400);
        rx_in(8'h99);
        chk("R4", "overflow flag", stat_word, 16'h0481);
        chk("R11", "irq on overflow", irq, 1'b1);
        stat_rd = 1'b1; sh_rx_vld = 1'b1; sh_rx_byte = 8'h98;
        chk("R9", "read sees old word", stat_word, 16'h0481);
        tick();
        stat_rd = 1'b0; sh_rx_vld = 1'b0;
        chk("R9", "event wins over read", stat_word, 16'h0481);
        stat_read();
        chk("R9", "cleared by read", stat_word, 16'h0400);
        for (int i = 0; i < 4; i++) rx_pop_chk("R4", 8'h10 + 8'(i));
        chk("R4", "dropped bytes absent", stat_word, 16'h0000);
    endtask

    task automatic t_tx_drain();
        mode_tx = 1'b1; thresh = 3'd1;
        for (int i = 0; i < 5; i++) tx_in(8'h21 + 8'(i));
        chk("R3", "tx count capped", stat_word, 16'h0008);
        for (int i = 0; i < 4; i++) begin
            chk("R2", "tx order", sh_tx_byte, 8'h21 + 8'(i));
            sh_tx_req = 1'b1;
            tick();
            sh_tx_req = 1'b0;
            if (i == 1) chk("R8", "no flag above threshold", stat_word, 16'h0004);
            if (i == 2) chk("R8", "flag at threshold", stat_word, 16'h0023);
        end
        chk("R8", "flag kept after empty", stat_word, 16'h0021);
        chk("R3", "write dropped when full", sh_tx_byte, 8'h00);
        stat_read();
        chk("R9", "tx flag cleared", stat_word, 16'h0000);
    endtask

    task automatic t_tx_underflow();
        mode_tx = 1'b1; thresh = 3'd1;
        chk("R5", "empty gives zero", sh_tx_byte, 8'h00);
        sh_tx_req = 1'b1;
        tick();
        sh_tx_req = 1'b0;
        chk("R5", "underflow flag", stat_word, 16'h0011);
        chk("R11", "irq on underflow", irq, 1'b1);
        tx_flush = 1'b1;
        #1;
        chk("R11", "underflow masked", irq, 1'b0);
        tx_wr = 1'b1; tx_wdata = 8'h55;
        tick();
        tx_wr = 1'b0; tx_flush = 1'b0;
        tick();
        chk("R10", "write ignored under flush", stat_word, 16'h0011);
        chk("R11", "mask released", irq, 1'b1);
        stat_read();
        chk("R9", "underflow cleared", stat_word, 16'h0000);
    endtask

    task automatic t_rx_flush();
        mode_tx = 1'b1; thresh = 3'd4;
        rx_in(8'h41); rx_in(8'h42);
        chk("R2", "two bytes", stat_word, 16'h0200);
        rx_flush = 1'b1; sh_rx_vld = 1'b1; sh_rx_byte = 8'h77;
        #1;
        chk("R10", "count zero while flush", stat_word, 16'h0000);
        tick();
        sh_rx_vld = 1'b0; rx_flush = 1'b0;
        tick();
        chk("R10", "empty after flush", stat_word, 16'h0000);
        chk("R10", "no data after flush", rx_rdata, 8'h00);
        for (int i = 0; i < 4; i++) rx_in(8'h31 + 8'(i));
        rx_in(8'h35);
        chk("R4", "overflow again", stat_word, 16'h0481);
        rx_flush = 1'b1;
        #1;
        chk("R11", "overflow masked", irq, 1'b0);
        chk("R10", "flag kept count zero", stat_word, 16'h0081);
        tick();
        rx_flush = 1'b0;
        #1;
        chk("R11", "overflow unmasked", irq, 1'b1);
        stat_read();
        chk("R9", "all clear", stat_word, 16'h0000);
    endtask

    initial begin
        rst = 1'b1; tx_wr = 1'b0; rx_rd = 1'b0; stat_rd = 1'b0;
        mode_tx = 1'b0; thresh = 3'd0; rx_flush = 1'b0; tx_flush = 1'b0;
        sh_rx_vld = 1'b0; sh_tx_req = 1'b0;
        tx_wdata = 8'h00; sh_rx_byte = 8'h00;
        #1;
        t_reset();
        t_rx_threshold();
        t_rx_overflow();
        t_tx_drain();
        t_tx_underflow();
        t_rx_flush();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule